// File: doc/BRIEF.md
# LCD Vertical Timing Generator

This block produces the vertical timing of an LCD panel from a pair of free-running counters clocked by the pixel clock. A pixel counter steps through each line. A line counter steps once per line and spans the frame. Two outputs are decoded from the frame position. The first is a display-enable window that covers a programmable run of lines. The second is a frame sync pulse. The sync pulse is placed in whole lines, but its start and stop edges can each be moved by their own offset in pixel clocks, so the pulse may begin and end partway through a line.

All configuration arrives on plain input ports and is copied into a shadow register. The copy is taken in two places: on the single load cycle that follows reset, and on the clock edge that returns both counters to zero. A change made in the middle of a frame therefore never disturbs the frame in progress. The sync output is driven by a small state machine with three states:

- `ST_LOAD` is held only after reset. It moves to `ST_OFF` or `ST_ON` on the first clock edge.
- `ST_OFF` moves to `ST_ON` when the next frame position enters the pulse window (assert).
- `ST_ON` moves back to `ST_OFF` when the next position leaves the window (release).

The frame wrap is not a state of its own. The state machine simply re-evaluates the window against the newly loaded configuration at position zero. The counters, the state and the display-enable are all registered from the same next-position decode, so every output lines up with the counter values shown in the same cycle.

Top module: `lcd_vtiming_gen`

## Requirements
- R1: While reset is asserted, and in the load cycle right after it, `pix_o`=0, `line_o`=0, `de_o`=0 and `fsync_o`=1. The value 1 is the inactive level for the reset polarity of 0.
- R2: `pix_o` counts 0..HT-1, one step per clock, and then returns to 0. `line_o` advances by one on each pixel wrap over 0..VT-1 and then returns to 0. The first cycle after the load cycle shows position (0,0).
- R3: `de_o` is 1 exactly when `line_o` lies in [disp_start, disp_start + disp_cnt + 1). The start line is used as given, with no +1.
- R4: Let the frame position be P = `line_o`×HT + `pix_o`. The sync pulse is active exactly when sync_line×HT + start_ofs ≤ P < (sync_line + sync_wid + 1)×HT + stop_ofs.
- R5: With `cfg_sync_pol`=1, `fsync_o` is 1 while the pulse is active. With `cfg_sync_pol`=0, `fsync_o` is 0 while the pulse is active and 1 otherwise.
- R6: The configuration inputs are taken only in the load cycle and on the edge at which both counters return to 0. A change at any other time leaves every output untouched until the next frame starts, and then takes effect in that first cycle at position (0,0).
- R7: The 3-bit width field gives 1 to 8 lines. A stop offset larger than HT moves the stop edge into a later line. The pulse is limited to the frame, because the position never exceeds VT×HT−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ht | input | 11 | Horizontal total HT in pixel clocks |
| cfg_vt | input | 10 | Vertical total VT in lines |
| cfg_disp_cnt | input | 10 | Display length minus one, in lines |
| cfg_disp_start | input | 10 | First line of the display window |
| cfg_sync_line | input | 10 | Line on which the sync pulse starts |
| cfg_sync_wid | input | 3 | Sync width minus one, in lines |
| cfg_sync_pol | input | 1 | Sync polarity, 1 = active high |
| cfg_start_ofs | input | 10 | Delay of the sync start edge, in pixel clocks |
| cfg_stop_ofs | input | 10 | Delay of the sync stop edge, in pixel clocks |
| pix_o | output | 11 | Pixel counter |
| line_o | output | 10 | Line counter |
| de_o | output | 1 | Vertical display-enable window |
| fsync_o | output | 1 | Frame sync pulse, at the selected polarity |

## Verification
Two functions can fall in the same cycle: the adoption of a new configuration at the frame boundary, and a sync pulse that starts at frame position zero. The bench provokes this by changing the configuration mid-frame to sync_line 0 with no start offset and the opposite polarity. It then requires that the first cycle at (0,0) already shows the active level under the new polarity. It also requires that every cycle before that boundary still follows the old settings. The bench judges this by comparing every cycle against its own counter and window model. That model latches the configuration only where R6 allows.

// File: rtl/lcdv_pkg.sv
package lcdv_pkg;
    localparam int HT_W  = 11;
    localparam int LN_W  = 10;
    localparam int WID_W = 3;
    localparam int OFS_W = 10;
    localparam int POS_W = HT_W + LN_W + 2;

    typedef struct packed {
        logic [HT_W-1:0]  ht;
        logic [LN_W-1:0]  vt;
        logic [LN_W-1:0]  disp_cnt;
        logic [LN_W-1:0]  disp_start;
        logic [LN_W-1:0]  sync_line;
        logic [WID_W-1:0] sync_wid;
        logic             sync_pol;
        logic [OFS_W-1:0] start_ofs;
        logic [OFS_W-1:0] stop_ofs;
    } vcfg_t;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_OFF  = 2'd1,
        ST_ON   = 2'd2
    } vst_e;
endpackage

// File: rtl/lcdv_counter.sv
module lcdv_counter
    import lcdv_pkg::*;
#(
    parameter int HW = HT_W,
    parameter int LW = LN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [HW-1:0] ht,
    input  logic [LW-1:0] vt,
    output logic [HW-1:0] pix_q,
    output logic [LW-1:0] line_q,
    output logic [HW-1:0] pix_n,
    output logic [LW-1:0] line_n,
    output logic          frame_wrap
);
    logic end_pix;
    logic end_line;

    always_comb begin
        end_pix    = (pix_q == ht - HW'(1));
        end_line   = (line_q == vt - LW'(1));
        frame_wrap = run && end_pix && end_line;
        pix_n      = pix_q;
        line_n     = line_q;
        if (run) begin
            if (end_pix) begin
                pix_n  = '0;
                line_n = end_line ? '0 : line_q + LW'(1);
            end else begin
                pix_n = pix_q + HW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q  <= '0;
            line_q <= '0;
        end else begin
            pix_q  <= pix_n;
            line_q <= line_n;
        end
    end
endmodule

// File: rtl/lcdv_window.sv
module lcdv_window
    import lcdv_pkg::*;
#(
    parameter int LW = LN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] line_n,
    input  logic [LW-1:0] disp_start,
    input  logic [LW-1:0] disp_cnt,
    output logic          de_q
);
    localparam int EW = LW + 1;
    logic [EW-1:0] lo_e;
    logic [EW-1:0] hi_e;
    logic [EW-1:0] ln_e;
    logic          de_d;

    always_comb begin
        ln_e = EW'(line_n);
        lo_e = EW'(disp_start);
        hi_e = EW'(disp_start) + EW'(disp_cnt) + EW'(1);
        de_d = (ln_e >= lo_e) && (ln_e < hi_e);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) de_q <= 1'b0;
        else        de_q <= de_d;
    end
endmodule

// File: rtl/lcdv_sync_fsm.sv
module lcdv_sync_fsm
    import lcdv_pkg::*;
#(
    parameter int HW = HT_W,
    parameter int LW = LN_W,
    parameter int WW = WID_W,
    parameter int OW = OFS_W,
    parameter int PW = POS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] pix_n,
    input  logic [LW-1:0] line_n,
    input  logic [HW-1:0] ht_nx,
    input  logic [LW-1:0] sync_line_nx,
    input  logic [WW-1:0] sync_wid_nx,
    input  logic [OW-1:0] start_ofs_nx,
    input  logic [OW-1:0] stop_ofs_nx,
    input  logic          pol_q,
    output vst_e          st_q,
    output logic          run,
    output logic          fsync
);
    logic [PW-1:0] pos_n;
    logic [PW-1:0] start_p;
    logic [PW-1:0] stop_p;
    logic          in_pulse;
    vst_e          st_d;

    // Window test on the position the counters take at this edge
    always_comb begin
        pos_n    = PW'(line_n) * PW'(ht_nx) + PW'(pix_n);
        start_p  = PW'(sync_line_nx) * PW'(ht_nx) + PW'(start_ofs_nx);
        stop_p   = (PW'(sync_line_nx) + PW'(sync_wid_nx) + PW'(1)) * PW'(ht_nx)
                   + PW'(stop_ofs_nx);
        in_pulse = (pos_n >= start_p) && (pos_n < stop_p);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LOAD: st_d = in_pulse ? ST_ON : ST_OFF;
            ST_OFF:  if (in_pulse)  st_d = ST_ON;
            ST_ON:   if (!in_pulse) st_d = ST_OFF;
            default: st_d = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_LOAD;
        else        st_q <= st_d;
    end

    always_comb begin
        run   = (st_q != ST_LOAD);
        fsync = (st_q == ST_ON) ? pol_q : ~pol_q;
    end
endmodule

// File: rtl/lcd_vtiming_gen.sv
module lcd_vtiming_gen
    import lcdv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HT_W-1:0]  cfg_ht,
    input  logic [LN_W-1:0]  cfg_vt,
    input  logic [LN_W-1:0]  cfg_disp_cnt,
    input  logic [LN_W-1:0]  cfg_disp_start,
    input  logic [LN_W-1:0]  cfg_sync_line,
    input  logic [WID_W-1:0] cfg_sync_wid,
    input  logic             cfg_sync_pol,
    input  logic [OFS_W-1:0] cfg_start_ofs,
    input  logic [OFS_W-1:0] cfg_stop_ofs,
    output logic [HT_W-1:0]  pix_o,
    output logic [LN_W-1:0]  line_o,
    output logic             de_o,
    output logic             fsync_o
);
    vcfg_t           cfg_in;
    vcfg_t           cfg_nx;
    vcfg_t           shadow_q;
    vst_e            st_q;
    logic            run;
    logic            frame_wrap;
    logic [HT_W-1:0] pix_n;
    logic [LN_W-1:0] line_n;

    always_comb begin
        cfg_in.ht         = cfg_ht;
        cfg_in.vt         = cfg_vt;
        cfg_in.disp_cnt   = cfg_disp_cnt;
        cfg_in.disp_start = cfg_disp_start;
        cfg_in.sync_line  = cfg_sync_line;
        cfg_in.sync_wid   = cfg_sync_wid;
        cfg_in.sync_pol   = cfg_sync_pol;
        cfg_in.start_ofs  = cfg_start_ofs;
        cfg_in.stop_ofs   = cfg_stop_ofs;
        // new settings only on the load cycle or the frame boundary
        cfg_nx = (!run || frame_wrap) ? cfg_in : shadow_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shadow_q <= '0;
        else        shadow_q <= cfg_nx;
    end

    lcdv_counter u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .ht         (shadow_q.ht),
        .vt         (shadow_q.vt),
        .pix_q      (pix_o),
        .line_q     (line_o),
        .pix_n      (pix_n),
        .line_n     (line_n),
        .frame_wrap (frame_wrap)
    );

    lcdv_window u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_n     (line_n),
        .disp_start (cfg_nx.disp_start),
        .disp_cnt   (cfg_nx.disp_cnt),
        .de_q       (de_o)
    );

    lcdv_sync_fsm u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_n        (pix_n),
        .line_n       (line_n),
        .ht_nx        (cfg_nx.ht),
        .sync_line_nx (cfg_nx.sync_line),
        .sync_wid_nx  (cfg_nx.sync_wid),
        .start_ofs_nx (cfg_nx.start_ofs),
        .stop_ofs_nx  (cfg_nx.stop_ofs),
        .pol_q        (shadow_q.sync_pol),
        .st_q         (st_q),
        .run          (run),
        .fsync        (fsync_o)
    );
endmodule

// File: rtl/lcdv_checker.sv
module lcdv_checker
    import lcdv_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [HT_W-1:0] pix,
    input logic [LN_W-1:0] line,
    input logic            de,
    input logic            fsync,
    input vcfg_t           sh,
    input vst_e            st
);
    // R1: the load cycle shows idle outputs
    p_load_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD) |-> (!de && fsync == !sh.sync_pol && pix == '0 && line == '0));

    // R2: the pixel counter steps by one inside a line
    p_pix_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_LOAD && pix != sh.ht - HT_W'(1)) |=> (pix == $past(pix) + HT_W'(1)));

    // R2: the line holds inside a line
    p_line_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_LOAD && pix != sh.ht - HT_W'(1)) |=> $stable(line));

    // R3: the enable stays inside the window
    p_de_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> ((line >= sh.disp_start) &&
                ({1'b0, line} < {1'b0, sh.disp_start} + {1'b0, sh.disp_cnt} + 11'd1)));

    // R6: settings are constant away from frame position zero
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix != '0 || line != '0) |-> $stable(sh));
endmodule

bind lcd_vtiming_gen lcdv_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .pix   (pix_o),
    .line  (line_o),
    .de    (de_o),
    .fsync (fsync_o),
    .sh    (shadow_q),
    .st    (st_q)
);

// File: tb/lcd_vtiming_gen_test.sv
module lcd_vtiming_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] cfg_ht = '0;
    logic [9:0]  cfg_vt = '0;
    logic [9:0]  cfg_disp_cnt = '0;
    logic [9:0]  cfg_disp_start = '0;
    logic [9:0]  cfg_sync_line = '0;
    logic [2:0]  cfg_sync_wid = '0;
    logic        cfg_sync_pol = 1'b0;
    logic [9:0]  cfg_start_ofs = '0;
    logic [9:0]  cfg_stop_ofs = '0;
    logic [10:0] pix_o;
    logic [9:0]  line_o;
    logic        de_o;
    logic        fsync_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model
    bit m_load;
    int m_pix, m_line;
    int m_ht, m_vt, m_dc, m_ds, m_sl, m_w, m_pol, m_sto, m_stpo;

    always #5 clk = ~clk;

    lcd_vtiming_gen uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_ht(cfg_ht), .cfg_vt(cfg_vt),
        .cfg_disp_cnt(cfg_disp_cnt), .cfg_disp_start(cfg_disp_start),
        .cfg_sync_line(cfg_sync_line), .cfg_sync_wid(cfg_sync_wid),
        .cfg_sync_pol(cfg_sync_pol),
        .cfg_start_ofs(cfg_start_ofs), .cfg_stop_ofs(cfg_stop_ofs),
        .pix_o(pix_o), .line_o(line_o), .de_o(de_o), .fsync_o(fsync_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int ht, input int vt, input int dc, input int ds,
                           input int sl, input int w, input int pol,
                           input int sto, input int stpo);
        cfg_ht = 11'(ht); cfg_vt = 10'(vt);
        cfg_disp_cnt = 10'(dc); cfg_disp_start = 10'(ds);
        cfg_sync_line = 10'(sl); cfg_sync_wid = 3'(w);
        cfg_sync_pol = pol[0];
        cfg_start_ofs = 10'(sto); cfg_stop_ofs = 10'(stpo);
    endtask

    task automatic latch;
        m_ht = int'(cfg_ht); m_vt = int'(cfg_vt);
        m_dc = int'(cfg_disp_cnt); m_ds = int'(cfg_disp_start);
        m_sl = int'(cfg_sync_line); m_w = int'(cfg_sync_wid);
        m_pol = int'(cfg_sync_pol);
        m_sto = int'(cfg_start_ofs); m_stpo = int'(cfg_stop_ofs);
    endtask

    // one clock: advance the model with the inputs seen at this edge, then compare
    task automatic tick(input string tag);
        int pos, st, sp, e_fs;
        bit act, e_de;
        if (m_load) begin
            latch(); m_pix = 0; m_line = 0; m_load = 1'b0;
        end else if (m_pix == m_ht - 1) begin
            m_pix = 0;
            if (m_line == m_vt - 1) begin
                m_line = 0; latch();
            end else m_line++;
        end else m_pix++;
        @(posedge clk);
        @(negedge clk);
        pos  = m_line * m_ht + m_pix;
        st   = m_sl * m_ht + m_sto;
        sp   = (m_sl + m_w + 1) * m_ht + m_stpo;
        act  = (pos >= st) && (pos < sp);
        e_fs = (m_pol != 0) ? int'(act) : int'(!act);
        e_de = (m_line >= m_ds) && (m_line < m_ds + m_dc + 1);
        chk(int'(pix_o) == m_pix, "R2", "pix_o", int'(pix_o), m_pix);
        chk(int'(line_o) == m_line, "R2", "line_o", int'(line_o), m_line);
        chk(de_o == e_de, (tag == "R6") ? tag : "R3", "de_o", int'(de_o), int'(e_de));
        chk(int'(fsync_o) == e_fs, tag, "fsync_o", int'(fsync_o), e_fs);
    endtask

    task automatic run_cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    // R1: reset and load-cycle outputs
    task automatic t_reset;
        rst_n = 1'b0;
        set_cfg(10, 12, 4, 2, 3, 1, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk(pix_o == '0, "R1", "pix_o in reset", int'(pix_o), 0);
        chk(line_o == '0, "R1", "line_o in reset", int'(line_o), 0);
        chk(de_o == 1'b0, "R1", "de_o in reset", int'(de_o), 0);
        chk(fsync_o == 1'b1, "R1", "fsync_o in reset", int'(fsync_o), 1);
        rst_n = 1'b1;
        m_load = 1'b1; m_pol = 0;
        #1;
        chk(de_o == 1'b0, "R1", "de_o load cycle", int'(de_o), 0);
        chk(fsync_o == 1'b1, "R1", "fsync_o load cycle", int'(fsync_o), 1);
        chk(pix_o == '0 && line_o == '0, "R1", "position load cycle",
            int'(pix_o) + int'(line_o), 0);
    endtask

    // R2, R3, R4: line-aligned pulse, active high
    task automatic t_base;
        run_cycles(2 * 120, "R4");
    endtask

    // R4: pulse edges moved inside lines by both offsets
    task automatic t_offsets;
        set_cfg(10, 12, 5, 3, 4, 0, 1, 4, 7);
        run_cycles(2 * 120 + 13, "R4");
    endtask

    // R5: active low, pulse at frame start, window from line 0 to frame end
    task automatic t_pol_low;
        set_cfg(10, 12, 11, 0, 0, 2, 0, 0, 3);
        run_cycles(3 * 120, "R5");
    endtask

    // R7: widest pulse, stop offset beyond HT, window running past the frame
    task automatic t_wide;
        set_cfg(9, 14, 2, 11, 8, 7, 1, 5, 13);
        run_cycles(3 * 126, "R7");
    endtask

    // R6: mid-frame change to pulse at position 0 with flipped polarity and new HT
    task automatic t_midframe;
        set_cfg(10, 12, 4, 2, 5, 1, 0, 2, 2);
        run_cycles(120 + 37, "R6");
        set_cfg(12, 11, 3, 6, 0, 0, 1, 0, 5);
        run_cycles(3 * 132, "R6");
    endtask

    initial begin
        t_reset();
        t_base();
        t_offsets();
        t_pol_low();
        t_wide();
        t_midframe();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule